// File: doc/BRIEF.md
# Serial and Parallel Configuration Latch

This block keeps the configuration word of a clock synthesizer: a 9-bit loop divider value, a 2-bit output divider value and a 3-bit test-mode field. Two independent paths can load it. A three-wire serial port shifts a 14-bit frame into a shift register on rising edges of its serial clock, and a load strobe that is high makes the configuration follow that register. A parallel port presents the loop and output divider values on pins, and a parallel strobe that is low makes the configuration follow those pins.

Both strobes act as level-sensitive latch enables: the configuration tracks its source while the enable is open and holds the value present at the closing edge. The serial strobe opens when high and closes on its falling edge. The parallel strobe opens when low and closes on its rising edge. All pins are asynchronous to the block clock. Each one passes through a synchronizer of `SYNC_STAGES` flops, and the latches are modelled as clock-enabled registers, so a pin change reaches the outputs `SYNC_STAGES + 1` clock edges later.

Top module: `cfg_word_latch`

## Requirements
- R1: While reset is asserted, and on release, the shift register and all three output fields (`cfg_m`, `cfg_n`, `cfg_t`) are zero.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register, and every other bit moves up one place. With the default of two synchronizer stages, the serial clock high and low times must each be at least three block clock cycles.
- R3: Bits of a frame map as follows. The first bit sent is T2, followed by T1, T0, N1, N0, then M8 down to M0, with M0 sent last. As a result, register bits [13:11] hold T, bits [10:9] hold N, and bits [8:0] hold M, with M8 as the most significant bit of M.
- R4: While `ser_load` is high, all three output fields follow the shift register, including bits shifted in during that time.
- R5: When `ser_load` falls, the outputs keep the captured value. Later shifting has no effect on the outputs until `ser_load` rises again.
- R6: Shifting a frame while `ser_load` is low, with `par_load` high, leaves all outputs unchanged.
- R7: While `par_load` is low, `cfg_m` follows `par_m` and `cfg_n` follows `par_n`.
- R8: When `par_load` rises, the outputs keep the captured value. Later changes on `par_m` or `par_n` have no effect.
- R9: A parallel load never changes `cfg_t`.
- R10: If both strobes are open at once (`ser_load` high and `par_load` low), the serial shift register takes priority for all fields.
- R11: If more than 14 bits are shifted before a load, only the last 14 bits are kept.
- R12: With the default two synchronizer stages, a strobe or data pin change driven between clock edges appears on the outputs after the third following rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data bit |
| ser_load | input | 1 | Serial latch enable, open while high |
| par_load | input | 1 | Parallel latch enable, open while low |
| par_m | input | 9 | Parallel loop divider value |
| par_n | input | 2 | Parallel output divider value |
| cfg_m | output | 9 | Latched loop divider |
| cfg_n | output | 2 | Latched output divider |
| cfg_t | output | 3 | Latched test-mode field |

## Verification
The stimulus combines directed cases with seeded random loads. The directed cases include frames shifted with the strobe closed, which separates latch behaviour from shift behaviour. They also shift a bit while the serial strobe is open, which shows transparency rather than edge capture. A 17-bit frame checks that the oldest bits are dropped, and both strobes are opened together to check priority. A parallel load after a distinctive serial T value shows whether T is left alone. Pin changes after a strobe closes separate a true hold from continued tracking. A cycle-counted strobe edge pins down the exact latency.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;

    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 3;
    localparam int FRAME_W = T_W + N_W + M_W;

    // Field order equals shift order: first bit sent lands in the MSB.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int FRAME_W = cfg_latch_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdata_s,
    output logic               shift_pulse,
    output logic [FRAME_W-1:0] shreg
);

    typedef struct packed {
        logic               sclk_prev;
        logic [FRAME_W-1:0] sh;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        shift_pulse    = sclk_s & ~st_q.sclk_prev;
        if (shift_pulse) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], sdata_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shreg = st_q.sh;

endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
    import cfg_latch_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sload_s,
    input  logic               pload_s,
    input  logic [FRAME_W-1:0] shreg,
    input  logic [M_W-1:0]     pm_s,
    input  logic [N_W-1:0]     pn_s,
    output cfg_word_t          cfg
);

    cfg_word_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sload_s) begin
            // serial enable open: whole word tracks the shift register
            cfg_d = cfg_word_t'(shreg);
        end else if (!pload_s) begin
            // parallel enable open: dividers track pins, test field kept
            cfg_d.m = pm_s;
            cfg_d.n = pn_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cfg_word_latch.sv
module cfg_word_latch
    import cfg_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t
);

    localparam int SER_W = 3;
    localparam int PAR_W = 1 + M_W + N_W;

    logic [SER_W-1:0]   ser_s;
    logic [PAR_W-1:0]   par_s;
    logic               ser_clk_s, ser_data_s, ser_load_s;
    logic               par_load_s;
    logic [M_W-1:0]     par_m_s;
    logic [N_W-1:0]     par_n_s;
    logic               ser_rise;
    logic [FRAME_W-1:0] shreg;
    cfg_word_t          cfg;

    // serial pins idle low, parallel pins idle high
    cfg_sync #(.W(SER_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ser_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_clk, ser_data, ser_load}),
        .dout (ser_s)
    );

    cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_par_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({par_load, par_m, par_n}),
        .dout (par_s)
    );

    assign {ser_clk_s, ser_data_s, ser_load_s} = ser_s;
    assign {par_load_s, par_m_s, par_n_s}      = par_s;

    cfg_shifter #(.FRAME_W(FRAME_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (ser_clk_s),
        .sdata_s    (ser_data_s),
        .shift_pulse(ser_rise),
        .shreg      (shreg)
    );

    cfg_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .sload_s(ser_load_s),
        .pload_s(par_load_s),
        .shreg  (shreg),
        .pm_s   (par_m_s),
        .pn_s   (par_n_s),
        .cfg    (cfg)
    );

    assign cfg_m = cfg.m;
    assign cfg_n = cfg.n;
    assign cfg_t = cfg.t;

endmodule

// File: rtl/cfg_latch_chk.sv
module cfg_latch_chk
    import cfg_latch_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ser_load_s,
    input logic               par_load_s,
    input logic               ser_data_s,
    input logic               ser_rise,
    input logic [FRAME_W-1:0] shreg,
    input logic [M_W-1:0]     par_m_s,
    input logic [N_W-1:0]     par_n_s,
    input logic [M_W-1:0]     cfg_m,
    input logic [N_W-1:0]     cfg_n,
    input logic [T_W-1:0]     cfg_t
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (shreg == '0 && cfg_m == '0 && cfg_n == '0 && cfg_t == '0));

    assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_rise |=> $stable(shreg));

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_rise |=> shreg[0] == $past(ser_data_s));

    assert_ser_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load_s |=> {cfg_t, cfg_n, cfg_m} == $past(shreg));

    assert_hold_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_load_s && par_load_s) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

    assert_par_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_load_s && !ser_load_s) |=> (cfg_m == $past(par_m_s) && cfg_n == $past(par_n_s)));

    assert_t_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_load_s |=> $stable(cfg_t));

    assert_ser_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_load_s && !par_load_s) |=> cfg_m == $past(shreg[M_W-1:0]));

endmodule

bind cfg_word_latch cfg_latch_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_load_s(ser_load_s),
    .par_load_s(par_load_s),
    .ser_data_s(ser_data_s),
    .ser_rise  (ser_rise),
    .shreg     (shreg),
    .par_m_s   (par_m_s),
    .par_n_s   (par_n_s),
    .cfg_m     (cfg_m),
    .cfg_n     (cfg_n),
    .cfg_t     (cfg_t)
);

// File: tb/cfg_word_latch_tb.sv
module cfg_word_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic       par_load = 1'b1;
    logic [8:0] par_m = '1;
    logic [1:0] par_n = '1;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    logic [13:0] exp_sh  = '0;
    logic [13:0] exp_cfg = '0;

    always #4 clk = ~clk;

    cfg_word_latch dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_clk (ser_clk),
        .ser_data(ser_data),
        .ser_load(ser_load),
        .par_load(par_load),
        .par_m   (par_m),
        .par_n   (par_n),
        .cfg_m   (cfg_m),
        .cfg_n   (cfg_n),
        .cfg_t   (cfg_t)
    );

    function automatic logic [13:0] pack_word(logic [2:0] t, logic [1:0] n, logic [8:0] m);
        return {t, n, m};
    endfunction

    function automatic logic [13:0] shift_model(logic [13:0] sh, logic b);
        return {sh[12:0], b};
    endfunction

    function automatic logic [13:0] par_model(logic [13:0] cur, logic [8:0] m, logic [1:0] n);
        return {cur[13:11], n, m};
    endfunction

    task automatic wait_n(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(string req, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] outw();
        return {cfg_t, cfg_n, cfg_m};
    endfunction

    task automatic shift_bit(logic b);
        ser_data = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        ser_clk = 1'b0;
        wait_n(4);
        exp_sh = shift_model(exp_sh, b);
    endtask

    task automatic shift_frame(logic [13:0] w);
        for (int i = 13; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic ser_pulse();
        ser_load = 1'b1;
        wait_n(6);
        ser_load = 1'b0;
        wait_n(6);
        exp_cfg = exp_sh;
    endtask

    task automatic par_word(logic [8:0] m, logic [1:0] n);
        par_m = m;
        par_n = n;
        par_load = 1'b0;
        wait_n(6);
        par_load = 1'b1;
        wait_n(6);
        exp_cfg = par_model(exp_cfg, m, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", 150000, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0429));
        wait_n(5);
        check("R1 reset state", outw(), 14'h0);
        rst_n = 1'b1;
        wait_n(4);
        check("R1 after release", outw(), 14'h0);

        // R6: shift without strobe, outputs stay
        shift_frame(pack_word(3'd5, 2'd2, 9'h1A5));
        check("R6 shift with strobe closed", outw(), 14'h0);

        // R3 frame order, R5 capture
        ser_pulse();
        check("R3 frame field map", outw(), pack_word(3'd5, 2'd2, 9'h1A5));
        check("R3 m field", {5'd0, cfg_m}, 14'h1A5);
        shift_frame(pack_word(3'd2, 2'd1, 9'h04B));
        check("R5 hold after serial close", outw(), pack_word(3'd5, 2'd2, 9'h1A5));

        // R4 transparency while high
        ser_load = 1'b1;
        wait_n(6);
        check("R4 follow register", outw(), pack_word(3'd2, 2'd1, 9'h04B));
        shift_bit(1'b1);
        check("R4 follow extra bit", outw(), exp_sh);
        ser_load = 1'b0;
        wait_n(6);
        exp_cfg = exp_sh;

        // R11 oversized frame
        for (int i = 0; i < 3; i++) shift_bit(1'b0);
        shift_frame(pack_word(3'd7, 2'd0, 9'h155));
        ser_pulse();
        check("R11 last 14 bits", outw(), pack_word(3'd7, 2'd0, 9'h155));

        // R7 parallel follow while low
        par_m = 9'h0F0;
        par_n = 2'd3;
        par_load = 1'b0;
        wait_n(6);
        check("R7 follow pins", outw(), pack_word(3'd7, 2'd3, 9'h0F0));
        par_m = 9'h00C;
        par_n = 2'd1;
        wait_n(6);
        check("R7 follow changed pins", outw(), pack_word(3'd7, 2'd1, 9'h00C));
        par_load = 1'b1;
        wait_n(6);
        par_m = 9'h1FF;
        par_n = 2'd2;
        wait_n(6);
        check("R8 hold after parallel close", outw(), pack_word(3'd7, 2'd1, 9'h00C));
        check("R9 t unchanged", {11'd0, cfg_t}, 14'd7);
        exp_cfg = pack_word(3'd7, 2'd1, 9'h00C);

        // R12 latency, driven at a negedge
        par_m = 9'h0A3;
        par_n = 2'd0;
        par_load = 1'b0;
        wait_n(2);
        check("R12 not after two edges", outw(), pack_word(3'd7, 2'd1, 9'h00C));
        wait_n(1);
        check("R12 after three edges", outw(), pack_word(3'd7, 2'd0, 9'h0A3));
        par_load = 1'b1;
        wait_n(6);
        exp_cfg = pack_word(3'd7, 2'd0, 9'h0A3);

        // R10 both open
        shift_frame(pack_word(3'd1, 2'd2, 9'h0D3));
        par_m = 9'h111;
        par_n = 2'd1;
        par_load = 1'b0;
        ser_load = 1'b1;
        wait_n(6);
        check("R10 serial priority", outw(), pack_word(3'd1, 2'd2, 9'h0D3));
        ser_load = 1'b0;
        par_load = 1'b1;
        wait_n(6);
        exp_cfg = outw() === pack_word(3'd1, 2'd2, 9'h0D3) ? outw() : pack_word(3'd1, 2'd2, 9'h0D3);
        par_m = '1;
        par_n = '1;

        // random mix
        for (int it = 0; it < 24; it++) begin
            int mode;
            logic [13:0] w;
            mode = $urandom % 3;
            w = 14'($urandom);
            if (mode == 0) begin
                shift_frame(w);
                ser_pulse();
                check("R3 random serial load", outw(), exp_cfg);
            end else if (mode == 1) begin
                par_word(w[8:0], w[10:9]);
                check("R9 random parallel load", outw(), exp_cfg);
            end else begin
                shift_frame(w);
                check("R6 random shift no load", outw(), exp_cfg);
            end
        end

        // R1 reset mid-operation
        rst_n = 1'b0;
        wait_n(3);
        check("R1 reset again", outw(), 14'h0);
        rst_n = 1'b1;
        wait_n(3);
        exp_sh = '0;
        ser_pulse();
        check("R1 register cleared", outw(), 14'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule